// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces a pulse-width-modulated output with a fixed period of 256 clock cycles. A free-running 8-bit ramp counter sets the period, and its live value is driven out on `count_o`. The duty request `duty_i` is 9 bits wide, so both a fully-off output (0) and a truly fully-on output (256) can be expressed. The output is high while the latched duty value is greater than the ramp value. A duty of N therefore gives exactly N high cycles in every period.

The duty request goes through a shadow register. The block copies the input into that register only on the clock edge where the counter wraps from its top value back to zero. A period in progress can never be cut short or stretched by a late duty change. The same edge raises `wrap_o` for one cycle, so a producer can use it to stage the next duty value.

Clearing `en_i` stops the ramp where it is and forces the output low. Setting it again resumes counting from the frozen value.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: While `en_i` is high, `count_o` steps up by one on each rising clock edge and goes from 255 to 0, giving a period of exactly 256 cycles.
- R2: In each cycle, `pwm_o` is high exactly when the latched duty value (unsigned) is greater than the `count_o` value shown in the same cycle. A period that starts at count 0 therefore has exactly N high cycles for a latched duty N ≤ 256.
- R3: A latched duty of 0 keeps `pwm_o` low for the whole period. A latched duty of 256 keeps it high in every cycle, including the cycle at count 0 and across the wrap.
- R4: The duty input is copied into the shadow register only on the enabled edge where the count goes from 255 to 0. The value present at that edge is the one taken, and any value applied at another time has no effect on `pwm_o` until the next wrap.
- R5: `wrap_o` is high for exactly one cycle: the cycle in which `count_o` first shows 0 after a wrap. It is low in every other cycle.
- R6: While `en_i` is low, `count_o` holds its value, `wrap_o` stays low and `pwm_o` is low from the first edge after `en_i` falls.
- R7: If `en_i` is low on the edge where the count reads 255, no wrap takes place and the duty is not loaded. The wrap and the load happen on the first enabled edge after that.
- R8: The asynchronous active-low reset sets the count, the latched duty, `pwm_o` and `wrap_o` to 0. After reset, `pwm_o` stays low until the first wrap loads a duty value.
- R9: Duty values from 257 to 511 behave like 256: the output is high in every cycle of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable; low freezes the ramp and forces the output low |
| duty_i | input | 9 | Requested duty in counts (0 to 256 meaningful) |
| pwm_o | output | 1 | PWM waveform |
| count_o | output | 8 | Current ramp counter value |
| wrap_o | output | 1 | One-cycle strobe in the cycle after the counter wraps to zero |

## Verification
The counter wrap and a change of the duty request can happen in the same cycle. The bench does this on purpose in every period. At count 100 it applies a junk duty value. On the cycle where the count reads 255 it applies the next real value, so the new value is present only on the wrap edge itself. The bench judges the result by counting the high cycles in the following period: the total must equal the last-moment value, never the junk one. A cycle-by-cycle arithmetic model also checks each output sample. A second collision, disabling on the count-255 edge, checks that the wrap and the load are deferred together.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Default ramp width; the period is 2**width clocks.
  localparam int unsigned PWM_DEF_CNT_W = 8;

  // Action the ramp counter takes on the next edge.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_WRAP = 2'b10
  } pwm_step_e;

endpackage

// File: rtl/pwm_ramp_counter.sv
module pwm_ramp_counter
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = PWM_DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_nxt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  pwm_step_e        step;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;

  // Next-state decision
  always_comb begin
    if (!en_i) begin
      step = STEP_HOLD;
    end else if (cnt_q == CntMax) begin
      step = STEP_WRAP;
    end else begin
      step = STEP_INC;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    unique case (step)
      STEP_INC: begin
        cnt_d = cnt_q + CntOne;
      end
      STEP_WRAP: begin
        cnt_d  = '0;
        wrap_d = 1'b1;
      end
      default: begin
        cnt_d = cnt_q;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_nxt_o  = cnt_d;
  assign wrap_nxt_o = wrap_d;
  assign wrap_o     = wrap_q;

  // R1: enabled top value goes to zero
  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == CntMax) |=> (cnt_q == '0));

  // R1: enabled non-top value steps by one
  a_r1_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != CntMax) |=> (cnt_q == $past(cnt_q) + CntOne));

  // R6: ramp frozen while disabled
  a_r6_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

  // R5: strobe lasts one cycle and coincides with count zero
  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> !wrap_q);

  a_r5_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> (cnt_q == '0));

  // R6, R7: no strobe without an enabled edge
  a_r7_no_idle_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wrap_q);

endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int unsigned DUTY_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] duty_nxt_o
);

  logic [DUTY_W-1:0] duty_q, duty_d;

  // Copy the request only on the wrap edge.
  always_comb begin
    if (load_i) begin
      duty_d = duty_i;
    end else begin
      duty_d = duty_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
    end else if (load_i) begin
      duty_q <= duty_d;
    end
  end

  assign duty_nxt_o = duty_d;

  // R4: shadow untouched away from the wrap
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(duty_q));

  // R4: value present at the wrap edge is captured
  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (duty_q == $past(duty_i)));

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DUTY_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic [DUTY_W-1:0] duty_nxt_i,
  output logic              pwm_o
);

  localparam int unsigned PadW = DUTY_W - CNT_W;

  logic [DUTY_W-1:0] cnt_ext;
  logic              pwm_q, pwm_d;

  assign cnt_ext = {{PadW{1'b0}}, cnt_nxt_i};

  // Level for the cycle that follows this edge
  always_comb begin
    if (en_i) begin
      pwm_d = (duty_nxt_i > cnt_ext);
    end else begin
      pwm_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // R6: output low after a disabled edge
  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_q);

  // R3: zero duty never drives high
  a_r3_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_nxt_i == '0) |=> !pwm_q);

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = PWM_DEF_CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [CNT_W:0]     duty_i,
  output logic               pwm_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               wrap_o
);

  localparam int unsigned DutyW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap_nxt;
  logic [DutyW-1:0] duty_nxt;

  pwm_ramp_counter #(
    .CNT_W (CNT_W)
  ) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cnt_o      (count_o),
    .cnt_nxt_o  (cnt_nxt),
    .wrap_nxt_o (wrap_nxt),
    .wrap_o     (wrap_o)
  );

  pwm_duty_shadow #(
    .DUTY_W (DutyW)
  ) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wrap_nxt),
    .duty_i     (duty_i),
    .duty_nxt_o (duty_nxt)
  );

  pwm_compare_out #(
    .CNT_W  (CNT_W),
    .DUTY_W (DutyW)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cnt_nxt_i  (cnt_nxt),
    .duty_nxt_i (duty_nxt),
    .pwm_o      (pwm_o)
  );

  // R3: full-scale duty keeps the output high through the wrap
  a_r3_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && duty_nxt >= DutyW'(1 << CNT_W)) |=> pwm_o);

endmodule

// File: tb/test_pwm_dbuf_gen.sv
module test_pwm_dbuf_gen;

  localparam int unsigned CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [8:0] duty;
  logic       pwm;
  logic [7:0] count;
  logic       wrap;

  int n_checks;
  int n_fail;

  // Reference state, computed from the requirements
  int m_cnt;
  int m_duty;
  bit m_wrap;
  bit m_pwm;

  pwm_dbuf_gen i_pwm_dbuf_gen (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .duty_i  (duty),
    .pwm_o   (pwm),
    .count_o (count),
    .wrap_o  (wrap)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Advance one edge; model update uses the inputs held across it.
  task automatic step();
    bit en_used;
    en_used = en;
    if (en_used) begin
      if (m_cnt == 255) begin
        m_cnt  = 0;
        m_duty = int'(duty);
        m_wrap = 1'b1;
      end else begin
        m_cnt++;
        m_wrap = 1'b0;
      end
    end else begin
      m_wrap = 1'b0;
    end
    m_pwm = en_used && (m_duty > m_cnt);
    @(posedge clk);
    #1;
    check(int'(count) == m_cnt, "R1 count", int'(count), m_cnt);
    check(wrap == m_wrap, "R5 wrap", int'(wrap), int'(m_wrap));
    check(pwm == m_pwm, "R2 pwm", int'(pwm), int'(m_pwm));
  endtask

  function automatic int hi_expect(input int d);
    return (d > 256) ? 256 : d;
  endfunction

  initial begin
    int seq[$];
    int hi;
    n_checks = 0;
    n_fail   = 0;
    rst_n = 1'b0;
    en    = 1'b0;
    duty  = 9'd256;
    m_cnt = 0; m_duty = 0; m_wrap = 0; m_pwm = 0;
    #(3*CLK_PERIOD + 2);
    // R8: reset state
    check(count == 8'd0, "R8 reset count", int'(count), 0);
    check(!pwm,  "R8 reset pwm",  int'(pwm), 0);
    check(!wrap, "R8 reset wrap", int'(wrap), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R8: first period runs with the cleared shadow even though duty_i=256
    en = 1'b1;
    hi = 0;
    for (int i = 0; i < 255; i++) begin
      step();
      if (pwm) hi++;
    end
    check(hi == 0, "R8 pre-load low", hi, 0);

    // Full sweep of duty values plus out-of-range ones (R9)
    for (int d = 0; d <= 256; d++) seq.push_back(d);
    seq.push_back(300);
    seq.push_back(511);
    seq.push_back(128);

    duty = 9'(seq[0]);
    step();  // wrap edge: loads seq[0]
    check(wrap == 1'b1, "R5 first wrap", int'(wrap), 1);
    for (int k = 0; k < seq.size() - 1; k++) begin
      hi = 0;
      for (int i = 0; i < 256; i++) begin
        if (pwm) hi++;
        if (m_cnt == 100) duty = 9'(511 - seq[k+1]);  // junk, must not load (R4)
        if (m_cnt == 255) duty = 9'(seq[k+1]);        // only on the wrap edge (R4)
        step();
      end
      if (seq[k] == 0)
        check(hi == 0, "R3 zero duty", hi, 0);
      else if (seq[k] >= 256)
        check(hi == 256, "R9/R3 full duty", hi, 256);
      else
        check(hi == hi_expect(seq[k]), "R2 high count", hi, hi_expect(seq[k]));
      check(wrap == 1'b1, "R4 wrap after period", int'(wrap), 1);
    end

    // R6: disable mid-period
    while (m_cnt != 50) step();
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      check(count == 8'd50, "R6 frozen count", int'(count), 50);
      check(!pwm,  "R6 pwm low", int'(pwm), 0);
      check(!wrap, "R6 wrap low", int'(wrap), 0);
    end
    en = 1'b1;

    // R7: disabled across the top value, duty changes meanwhile
    while (m_cnt != 255) step();
    en   = 1'b0;
    duty = 9'd7;
    for (int i = 0; i < 10; i++) begin
      step();
      check(count == 8'd255 && !wrap, "R7 no wrap while idle", int'(count), 255);
    end
    duty = 9'd3;
    en   = 1'b1;
    step();
    check(wrap && count == 8'd0, "R7 deferred wrap", int'(count), 0);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm) hi++;
      step();
    end
    check(hi == 3, "R7 deferred load", hi, 3);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // Watchdog
  initial begin
    #(150000 * CLK_PERIOD);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule